// File: doc/BRIEF.md
# NAND Programmed-I/O Command Dispatcher

This block is the register-driven front end of a NAND flash controller in programmed-I/O mode. Software loads a few 32-bit parameter registers (row address, auxiliary row or feature value, bank) and then writes the trigger register at offset 0x000. On that write the block checks and decodes the command word. It stores the request in a slot for the named thread, one of eight, and marks that thread busy.

A single sequencer then serves pending threads one at a time. It expands each request into a counted burst of single low-level flash operations. Each operation goes out on a valid/ready request port with its kind, row address, auxiliary word, feature address and DMA engine select. The row address is stepped between operations. When a thread's last operation is accepted, its busy flag drops. If the request asked for it, the thread's bit is also set in a write-one-to-clear interrupt status register.

Top module: `nand_pio_dispatch`

## Requirements
- R1: A write to offset 0x000 is the trigger. The parameters used are those held in offsets 0x004 (row), 0x008 (auxiliary) and 0x020 (bank in bits 31:24) at the time of the trigger write. Later writes to them do not alter an accepted request.
- R2: Trigger word fields: bits 31:30 mode (must be 01), bits 26:24 thread, bit 21 DMA select, bit 20 interrupt request, bits 19:16 volume (must be 0), bits 15:0 opcode. Opcodes: 0x22PP read, 0x21PP program, 0x12PP copyback, 0x10PP erase, 0x1100/0x1101/0x1102 reset, 0x0100 set-feature. The opKind codes on the request port are 0 read, 1 program, 2 copyback, 3 erase, 4 asynchronous reset, 5 synchronous reset, 6 LUN reset and 7 set-feature.
- R3: Read, program, copyback and erase issue PP+1 operations (1 to 256). The reset kinds and set-feature issue exactly one. opLast is high on the final operation of a request only.
- R4: The row address of operation i is base+i for read, program and copyback, and base+i*PAGES_PER_BLOCK for erase. For copyback the auxiliary word is the destination row, which steps by one in the same way.
- R5: Asynchronous and synchronous resets carry row 0. LUN reset carries the row from offset 0x004. A reset with PP above 2 is rejected.
- R6: Set-feature (exactly 0x0100) issues one operation with row 0, opFeatAddr equal to bits 7:0 of offset 0x004 and opAux equal to offset 0x008.
- R7: opDmaMaster reflects trigger bit 21 for read and program and is 0 for every other kind.
- R8: A trigger is rejected in any of these cases: the mode is not 01, the volume is nonzero, the opcode is unknown, the thread is busy, or the bank is nonzero for read, program, copyback or erase. A rejected trigger dispatches nothing and sets the sticky error output, which is read as bit 0 at offset 0x13C and cleared by writing 1 there.
- R9: threadBusy[t] rises on the cycle after thread t's trigger is accepted. It falls on the cycle after that thread's last operation is accepted. It stays high while any of its operations is presented.
- R10: If bit 20 was set, completion sets bit t of the status register at offset 0x138 (bits 7:0). Writing 1s there clears those bits, and irq is high whenever any status bit is set.
- R11: While opValid is high and opReady is low, every request field holds its value.
- R12: A request runs to completion before another starts. When the sequencer is free it takes the lowest-numbered pending thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset for read or write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data (status and error offsets) |
| opValid | output | 1 | Low-level operation presented |
| opReady | input | 1 | Consumer accepts the operation |
| opKind | output | 3 | Operation kind code |
| opThread | output | 3 | Thread that owns the operation |
| opRow | output | 32 | Row address (source row for copyback) |
| opAux | output | 32 | Copyback destination row or feature value |
| opFeatAddr | output | 8 | Feature address for set-feature |
| opDmaMaster | output | 1 | DMA engine select for read and program |
| opLast | output | 1 | Final operation of the request |
| threadBusy | output | 8 | Per-thread busy flags |
| irq | output | 1 | Any completion status bit set |
| cmdError | output | 1 | Sticky rejected-trigger flag |

## Verification
The hardest state to reach from the ports is several threads pending behind a stalled burst, together with a retrigger of the thread that is running. Reaching it needs the consumer to hold opReady low while new triggers arrive. The bench does this directly: it stalls the request port, starts one thread, retriggers it, queues two lower and higher numbered threads, and then releases the stall to observe the start order. A long random phase with random opReady back-pressure and random thread choice also collides triggers with busy threads and with completions in the same cycle. The bench models the busy window cycle-exactly to predict each rejection.

// File: rtl/nand_pio_pkg.sv
package nand_pio_pkg;

  localparam int TRD_W   = 3;
  localparam int NUM_TRD = 1 << TRD_W;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 8;
  localparam int FEAT_W  = 8;

  localparam logic [ADDR_W-1:0] A_TRIG = 12'h000;
  localparam logic [ADDR_W-1:0] A_ROW  = 12'h004;
  localparam logic [ADDR_W-1:0] A_AUX  = 12'h008;
  localparam logic [ADDR_W-1:0] A_BANK = 12'h020;
  localparam logic [ADDR_W-1:0] A_INTR = 12'h138;
  localparam logic [ADDR_W-1:0] A_ERR  = 12'h13C;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_PROG      = 3'd1,
    OP_COPY      = 3'd2,
    OP_ERASE     = 3'd3,
    OP_RST_ASYNC = 3'd4,
    OP_RST_SYNC  = 3'd5,
    OP_RST_LUN   = 3'd6,
    OP_SET_FEAT  = 3'd7
  } op_kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             capture;
    logic [TRD_W-1:0] capThread;
    op_kind_e         capKind;
    logic [CNT_W-1:0] capLast;
    logic             capIrq;
    logic             capDma;
    logic             load;
    logic [TRD_W-1:0] loadThread;
    logic             step;
  } strobe_t;

  // one captured request
  typedef struct packed {
    op_kind_e          kind;
    logic [CNT_W-1:0]  last;
    logic              irq;
    logic              dma;
    logic [DATA_W-1:0] row;
    logic [DATA_W-1:0] aux;
    logic [FEAT_W-1:0] feat;
  } slot_t;

endpackage

// File: rtl/nand_pio_ctrl.sv
module nand_pio_ctrl
  import nand_pio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [7:0]         stagedBank,
  input  logic               opReady,
  input  logic [CNT_W-1:0]   runLast,
  input  logic               runIrq,
  output strobe_t            strobe,
  output logic               opValid,
  output logic               opLast,
  output logic [NUM_TRD-1:0] threadBusy,
  output logic [NUM_TRD-1:0] intrStatus,
  output logic               cmdError,
  output logic [DATA_W-1:0]  regRdData
);

  // trigger word fields
  logic             trigWr;
  logic [1:0]       ctField;
  logic [TRD_W-1:0] thrField;
  logic             dmaBit;
  logic             irqBit;
  logic [3:0]       volField;
  logic [7:0]       opHi;
  logic [7:0]       ppField;
  logic             unusedTrigBits;

  assign trigWr         = regWrEn && (regAddr == A_TRIG);
  assign ctField        = regWrData[31:30];
  assign thrField       = regWrData[26:24];
  assign dmaBit         = regWrData[21];
  assign irqBit         = regWrData[20];
  assign volField       = regWrData[19:16];
  assign opHi           = regWrData[15:8];
  assign ppField        = regWrData[7:0];
  assign unusedTrigBits = ^{regWrData[29:27], regWrData[23:22]};

  // opcode decode
  logic             decKnown;
  op_kind_e         decKind;
  logic [CNT_W-1:0] decLast;

  always_comb begin
    decKnown = 1'b1;
    decKind  = OP_READ;
    decLast  = ppField;
    case (opHi)
      8'h22: decKind = OP_READ;
      8'h21: decKind = OP_PROG;
      8'h12: decKind = OP_COPY;
      8'h10: decKind = OP_ERASE;
      8'h11: begin
        decLast = '0;
        case (ppField)
          8'h00:   decKind = OP_RST_ASYNC;
          8'h01:   decKind = OP_RST_SYNC;
          8'h02:   decKind = OP_RST_LUN;
          default: decKnown = 1'b0;
        endcase
      end
      8'h01: begin
        decLast  = '0;
        decKind  = OP_SET_FEAT;
        decKnown = (ppField == 8'h00);
      end
      default: decKnown = 1'b0;
    endcase
  end

  logic needsBank;
  logic accept;
  logic reject;

  assign needsBank = (decKind == OP_READ) || (decKind == OP_PROG) ||
                     (decKind == OP_COPY) || (decKind == OP_ERASE);
  assign accept = trigWr && decKnown && (ctField == 2'b01) && (volField == 4'd0) &&
                  !threadBusy[thrField] && (!needsBank || (stagedBank == 8'd0));
  assign reject = trigWr && !accept;

  // sequencer state
  logic               running;
  logic [CNT_W-1:0]   idx;
  logic [TRD_W-1:0]   runThread;
  logic [NUM_TRD-1:0] pending;

  // fixed-priority pick: lowest pending thread
  logic [TRD_W-1:0] pick;
  logic             pickFound;

  always_comb begin
    pick      = '0;
    pickFound = 1'b0;
    for (int i = 0; i < NUM_TRD; i++) begin
      if (pending[i] && !pickFound) begin
        pick      = TRD_W'(i);
        pickFound = 1'b1;
      end
    end
  end

  logic fire;
  logic loadNow;

  assign opValid = running;
  assign opLast  = (idx == runLast);
  assign fire    = running && opReady;
  assign loadNow = !running && pickFound;

  always_comb begin
    strobe            = '0;
    strobe.capture    = accept;
    strobe.capThread  = thrField;
    strobe.capKind    = decKind;
    strobe.capLast    = decLast;
    strobe.capIrq     = irqBit;
    strobe.capDma     = dmaBit && ((decKind == OP_READ) || (decKind == OP_PROG));
    strobe.load       = loadNow;
    strobe.loadThread = pick;
    strobe.step       = fire && !opLast;
  end

  logic [NUM_TRD-1:0] capMask;
  logic [NUM_TRD-1:0] loadMask;
  logic [NUM_TRD-1:0] doneMask;
  logic [NUM_TRD-1:0] intrSet;
  logic [NUM_TRD-1:0] intrClr;
  logic               errClr;

  assign capMask  = accept  ? (NUM_TRD'(1) << thrField)  : '0;
  assign loadMask = loadNow ? (NUM_TRD'(1) << pick)      : '0;
  assign doneMask = (fire && opLast) ? (NUM_TRD'(1) << runThread) : '0;
  assign intrSet  = runIrq ? doneMask : '0;
  assign intrClr  = (regWrEn && (regAddr == A_INTR)) ? regWrData[NUM_TRD-1:0] : '0;
  assign errClr   = regWrEn && (regAddr == A_ERR) && regWrData[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      idx        <= '0;
      runThread  <= '0;
      pending    <= '0;
      threadBusy <= '0;
      intrStatus <= '0;
      cmdError   <= 1'b0;
    end else begin
      pending    <= (pending & ~loadMask) | capMask;
      threadBusy <= (threadBusy & ~doneMask) | capMask;
      intrStatus <= (intrStatus & ~intrClr) | intrSet;
      if (reject) begin
        cmdError <= 1'b1;
      end else if (errClr) begin
        cmdError <= 1'b0;
      end
      if (loadNow) begin
        running   <= 1'b1;
        idx       <= '0;
        runThread <= pick;
      end else if (fire) begin
        if (opLast) begin
          running <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (regAddr)
      A_INTR:  regRdData = DATA_W'(intrStatus);
      A_ERR:   regRdData = DATA_W'(cmdError);
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/nand_pio_dp.sv
module nand_pio_dp
  import nand_pio_pkg::*;
#(
  parameter int PAGES_PER_BLOCK = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  strobe_t           strobe,
  output logic [7:0]        stagedBank,
  output logic [CNT_W-1:0]  runLast,
  output logic              runIrq,
  output logic [2:0]        opKind,
  output logic [TRD_W-1:0]  opThread,
  output logic [DATA_W-1:0] opRow,
  output logic [DATA_W-1:0] opAux,
  output logic [FEAT_W-1:0] opFeatAddr,
  output logic              opDmaMaster
);

  localparam logic [DATA_W-1:0] BLOCK_STEP = DATA_W'(PAGES_PER_BLOCK);

  // staging registers written by software before the trigger
  logic [DATA_W-1:0] rowReg;
  logic [DATA_W-1:0] auxReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowReg     <= '0;
      auxReg     <= '0;
      stagedBank <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_ROW)  rowReg     <= regWrData;
      if (regAddr == A_AUX)  auxReg     <= regWrData;
      if (regAddr == A_BANK) stagedBank <= regWrData[31:24];
    end
  end

  // request contents shaped by kind at capture time
  slot_t capSlot;

  always_comb begin
    capSlot      = '0;
    capSlot.kind = strobe.capKind;
    capSlot.last = strobe.capLast;
    capSlot.irq  = strobe.capIrq;
    capSlot.dma  = strobe.capDma;
    case (strobe.capKind)
      OP_RST_ASYNC, OP_RST_SYNC: capSlot.row = '0;
      OP_SET_FEAT: begin
        capSlot.row  = '0;
        capSlot.aux  = auxReg;
        capSlot.feat = rowReg[FEAT_W-1:0];
      end
      OP_COPY: begin
        capSlot.row = rowReg;
        capSlot.aux = auxReg;
      end
      default: capSlot.row = rowReg;
    endcase
  end

  // one slot per thread
  slot_t [NUM_TRD-1:0] slotBus;

  for (genvar g = 0; g < NUM_TRD; g++) begin : gen_slot
    slot_t slotQ;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotQ <= '0;
      end else if (strobe.capture && (strobe.capThread == TRD_W'(g))) begin
        slotQ <= capSlot;
      end
    end
    assign slotBus[g] = slotQ;
  end

  // the running request, stepped per accepted operation
  slot_t            cur;
  logic [TRD_W-1:0] curThread;
  logic [DATA_W-1:0] rowStep;

  always_comb begin
    case (cur.kind)
      OP_READ, OP_PROG, OP_COPY: rowStep = DATA_W'(1);
      OP_ERASE:                  rowStep = BLOCK_STEP;
      default:                   rowStep = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= '0;
      curThread <= '0;
    end else if (strobe.load) begin
      cur       <= slotBus[strobe.loadThread];
      curThread <= strobe.loadThread;
    end else if (strobe.step) begin
      cur.row <= cur.row + rowStep;
      if (cur.kind == OP_COPY) begin
        cur.aux <= cur.aux + DATA_W'(1);
      end
    end
  end

  assign runLast     = cur.last;
  assign runIrq      = cur.irq;
  assign opKind      = cur.kind;
  assign opThread    = curThread;
  assign opRow       = cur.row;
  assign opAux       = cur.aux;
  assign opFeatAddr  = cur.feat;
  assign opDmaMaster = cur.dma;

endmodule

// File: rtl/nand_pio_dispatch.sv
module nand_pio_dispatch
  import nand_pio_pkg::*;
#(
  parameter int PAGES_PER_BLOCK = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         regWrEn,
  input  logic [11:0]  regAddr,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  output logic         opValid,
  input  logic         opReady,
  output logic [2:0]   opKind,
  output logic [2:0]   opThread,
  output logic [31:0]  opRow,
  output logic [31:0]  opAux,
  output logic [7:0]   opFeatAddr,
  output logic         opDmaMaster,
  output logic         opLast,
  output logic [7:0]   threadBusy,
  output logic         irq,
  output logic         cmdError
);

  strobe_t            strobe;
  logic [7:0]         stagedBank;
  logic [CNT_W-1:0]   runLast;
  logic               runIrq;
  logic [NUM_TRD-1:0] intrStatus;

  nand_pio_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .stagedBank (stagedBank),
    .opReady    (opReady),
    .runLast    (runLast),
    .runIrq     (runIrq),
    .strobe     (strobe),
    .opValid    (opValid),
    .opLast     (opLast),
    .threadBusy (threadBusy),
    .intrStatus (intrStatus),
    .cmdError   (cmdError),
    .regRdData  (regRdData)
  );

  nand_pio_dp #(.PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .strobe      (strobe),
    .stagedBank  (stagedBank),
    .runLast     (runLast),
    .runIrq      (runIrq),
    .opKind      (opKind),
    .opThread    (opThread),
    .opRow       (opRow),
    .opAux       (opAux),
    .opFeatAddr  (opFeatAddr),
    .opDmaMaster (opDmaMaster)
  );

  assign irq = |intrStatus;

endmodule

// File: rtl/nand_pio_checker.sv
module nand_pio_checker #(
  parameter int PAGES_PER_BLOCK = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        regWrEn,
  input logic [11:0] regAddr,
  input logic        opValid,
  input logic        opReady,
  input logic [2:0]  opKind,
  input logic [2:0]  opThread,
  input logic [31:0] opRow,
  input logic [31:0] opAux,
  input logic        opLast,
  input logic [7:0]  threadBusy,
  input logic        cmdError
);

  // R11: request fields hold under back-pressure
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && !opReady |=> opValid && $stable(opRow) && $stable(opAux) &&
                            $stable(opKind) && $stable(opThread) && $stable(opLast));

  // R9: an operation is only presented for a busy thread
  a_r9_busy_valid: assert property (@(posedge clk) disable iff (!rst_n)
    opValid |-> threadBusy[opThread]);

  // R9: busy drops after the last operation is taken
  a_r9_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && opReady && opLast |=> !threadBusy[$past(opThread)]);

  // R4: page stepping for read, program, copyback
  a_r4_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && opReady && !opLast && (opKind <= 3'd2) |=>
      opValid && (opRow == $past(opRow) + 32'd1));

  // R4: block stepping for erase
  a_r4_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && opReady && !opLast && (opKind == 3'd3) |=>
      opValid && (opRow == $past(opRow) + 32'(PAGES_PER_BLOCK)));

  // R12: a burst is not interleaved with another thread
  a_r12_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && opReady && !opLast |=> opValid && (opThread == $past(opThread)));

  // R8: the error flag only rises after a trigger write
  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdError) |-> $past(regWrEn && (regAddr == 12'h000)));

  // R5/R6: single-shot kinds with zero row
  a_r6_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    opValid && ((opKind == 3'd4) || (opKind == 3'd5) || (opKind == 3'd7)) |->
      opLast && (opRow == 32'd0));

endmodule

bind nand_pio_dispatch nand_pio_checker #(.PAGES_PER_BLOCK(PAGES_PER_BLOCK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .opValid    (opValid),
  .opReady    (opReady),
  .opKind     (opKind),
  .opThread   (opThread),
  .opRow      (opRow),
  .opAux      (opAux),
  .opLast     (opLast),
  .threadBusy (threadBusy),
  .cmdError   (cmdError)
);

// File: tb/nand_pio_dispatch_tb.sv
`timescale 1ns/1ps
module nand_pio_dispatch_tb;

  localparam int PPB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        opValid;
  logic        opReady = 1'b0;
  logic [2:0]  opKind;
  logic [2:0]  opThread;
  logic [31:0] opRow;
  logic [31:0] opAux;
  logic [7:0]  opFeatAddr;
  logic        opDmaMaster;
  logic        opLast;
  logic [7:0]  threadBusy;
  logic        irq;
  logic        cmdError;

  nand_pio_dispatch #(.PAGES_PER_BLOCK(PPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .opValid(opValid),
    .opReady(opReady), .opKind(opKind), .opThread(opThread), .opRow(opRow),
    .opAux(opAux), .opFeatAddr(opFeatAddr), .opDmaMaster(opDmaMaster),
    .opLast(opLast), .threadBusy(threadBusy), .irq(irq), .cmdError(cmdError)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit summaryDone = 0;
  int readyMode = 0;   // 0 never, 1 always, 2 random

  always @(posedge clk) cyc <= cyc + 1;

  // per-thread expected model
  bit          mAct [8];
  int          mKind [8];
  int          mLast [8];
  int          mIdx [8];
  logic [31:0] mRow [8];
  logic [31:0] mAux [8];
  bit          mDma [8];
  bit          mIrq [8];
  int          mDoneCyc [8];
  logic [7:0]  expIntr = '0;
  int          startLog [512];
  int          startCnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cyc), 32'd0);
    finishRun();
  end

  function automatic int benchKind(input logic [15:0] op);
    case (op[15:8])
      8'h22: return 0;
      8'h21: return 1;
      8'h12: return 2;
      8'h10: return 3;
      8'h11: return (op[7:0] == 8'd0) ? 4 : (op[7:0] == 8'd1) ? 5 : (op[7:0] == 8'd2) ? 6 : -1;
      8'h01: return (op[7:0] == 8'd0) ? 7 : -1;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] opcodeFor(input int k, input logic [7:0] pp);
    case (k)
      0: return {8'h22, pp};
      1: return {8'h21, pp};
      2: return {8'h12, pp};
      3: return {8'h10, pp};
      4: return 16'h1100;
      5: return 16'h1101;
      6: return 16'h1102;
      default: return 16'h0100;
    endcase
  endfunction

  function automatic logic [31:0] expRow(input int t, input int i);
    case (mKind[t])
      0, 1, 2: return mRow[t] + 32'(i);
      3:       return mRow[t] + 32'(i) * 32'(PPB);
      6:       return mRow[t];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] expAux(input int t, input int i);
    case (mKind[t])
      2:       return mAux[t] + 32'(i);
      7:       return mAux[t];
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit anyAct();
    for (int t = 0; t < 8; t++) if (mAct[t]) return 1;
    return 0;
  endfunction

  function automatic bit modelFree(input int t);
    return !mAct[t] && (mDoneCyc[t] != cyc);
  endfunction

  // consumer: decides ready, checks each accepted operation
  initial begin
    for (int t = 0; t < 8; t++) begin
      mAct[t] = 0;
      mDoneCyc[t] = -1;
    end
    forever begin
      @(negedge clk);
      opReady = (readyMode == 1) ? 1'b1 : (readyMode == 2) ? 1'($urandom_range(0, 1)) : 1'b0;
      if (rst_n && opValid && opReady) begin
        int t;
        int i;
        t = int'(opThread);
        if (!mAct[t]) begin
          chk(1'b0, "R8/R12 unexpected operation", {29'd0, opThread}, 32'hFFFF_FFFF);
        end else begin
          i = mIdx[t];
          if (i == 0) begin
            startLog[startCnt % 512] = t;
            startCnt++;
          end
          chk(opKind == 3'(mKind[t]), "R2 kind", 32'(opKind), 32'(mKind[t]));
          chk(opRow == expRow(t, i), "R4/R5 row", opRow, expRow(t, i));
          chk(opAux == expAux(t, i), "R4/R6 aux", opAux, expAux(t, i));
          chk(opFeatAddr == ((mKind[t] == 7) ? mRow[t][7:0] : 8'd0), "R6 feature address",
              32'(opFeatAddr), 32'((mKind[t] == 7) ? mRow[t][7:0] : 8'd0));
          chk(opDmaMaster == ((mKind[t] <= 1) ? mDma[t] : 1'b0), "R7 dma select",
              32'(opDmaMaster), 32'((mKind[t] <= 1) ? mDma[t] : 1'b0));
          chk(opLast == (i == mLast[t]), "R3 last flag", 32'(opLast), 32'(i == mLast[t]));
          mIdx[t] = i + 1;
          if (i == mLast[t]) begin
            mAct[t] = 0;
            mDoneCyc[t] = cyc;
            if (mIrq[t]) expIntr[t] = 1'b1;
          end
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
  endtask

  task automatic idle();
    @(negedge clk); #2;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); #2;
    regWrEn = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic issue(input int t, input logic [15:0] op, input logic [31:0] row,
                       input logic [31:0] aux, input logic [7:0] bank, input bit irqReq,
                       input bit dma, input logic [1:0] ct, input logic [3:0] vol);
    int k;
    bit acc;
    logic [31:0] d;
    wr(12'h004, row);
    wr(12'h008, aux);
    wr(12'h020, {bank, 24'h0});
    @(negedge clk); #2;
    k = benchKind(op);
    acc = (ct == 2'b01) && (vol == 4'd0) && (k >= 0) && modelFree(t) && (k > 3 || bank == 8'd0);
    regWrEn = 1'b1; regAddr = 12'h000;
    regWrData = {ct, 3'b000, 3'(t), 2'b00, dma, irqReq, vol, op};
    if (acc) begin
      mAct[t] = 1; mKind[t] = k; mIdx[t] = 0;
      mLast[t] = (k <= 3) ? int'(op[7:0]) : 0;
      mRow[t] = row; mAux[t] = aux; mDma[t] = dma; mIrq[t] = irqReq;
    end
    // later staging writes must not disturb the accepted request (R1)
    wr(12'h004, 32'hFFFF_0000);
    rd(12'h13C, d);
    chk(d[0] == !acc, "R8 error flag after trigger", d, 32'(!acc));
    if (!acc) begin
      wr(12'h13C, 32'd1);
      rd(12'h13C, d);
      chk(d[0] == 1'b0, "R8 error clear", d, 32'd0);
    end
  endtask

  task automatic waitIdle();
    while (anyAct()) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    int base;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(opValid == 1'b0, "R9 reset opValid", 32'(opValid), 32'd0);
    chk(threadBusy == 8'd0, "R9 reset busy", 32'(threadBusy), 32'd0);
    chk(irq == 1'b0 && cmdError == 1'b0, "R10 reset irq/error", {30'd0, irq, cmdError}, 32'd0);
    rd(12'h138, d);
    chk(d == 32'd0, "R10 reset status", d, 32'd0);

    readyMode = 1;
    // R1 R3 R7: read of four pages, DMA master, interrupt
    issue(0, 16'h2203, 32'h0000_1000, 32'h0, 8'h00, 1, 1, 2'b01, 4'd0);
    waitIdle();
    rd(12'h138, d);
    chk(d[7:0] == 8'h01, "R10 completion bit", d, 32'h1);
    chk(irq == 1'b1, "R10 irq output", 32'(irq), 32'd1);
    // R4: 256-block erase
    issue(3, 16'h10FF, 32'h0000_0040, 32'h0, 8'h00, 0, 1, 2'b01, 4'd0);
    // R4: copyback with destination stepping, program with DMA slave
    issue(2, 16'h1202, 32'd10, 32'd5000, 8'h00, 1, 1, 2'b01, 4'd0);
    issue(1, 16'h2101, 32'h0000_2222, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    // R5: reset kinds, R6: set-feature
    issue(4, 16'h1100, 32'h0000_ABCD, 32'h0, 8'h00, 0, 1, 2'b01, 4'd0);
    issue(5, 16'h1101, 32'h0000_ABCD, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    issue(6, 16'h1102, 32'h0000_0077, 32'h0, 8'h00, 1, 0, 2'b01, 4'd0);
    issue(7, 16'h0100, 32'h1234_56A5, 32'hDEAD_BEEF, 8'h00, 0, 1, 2'b01, 4'd0);
    waitIdle();

    // R8: rejection cases
    issue(0, 16'h2200, 32'h5, 32'h0, 8'h00, 0, 0, 2'b10, 4'd0);
    issue(0, 16'h2200, 32'h5, 32'h0, 8'h00, 0, 0, 2'b01, 4'd1);
    issue(0, 16'h2300, 32'h5, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    issue(0, 16'h1103, 32'h5, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    issue(0, 16'h0101, 32'h5, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    issue(0, 16'h2200, 32'h5, 32'h0, 8'h01, 0, 0, 2'b01, 4'd0);
    issue(0, 16'h1100, 32'h5, 32'h0, 8'h01, 0, 0, 2'b01, 4'd0);
    waitIdle();

    // R12 R9 R11: stalled burst, busy retrigger, queued threads
    readyMode = 0;
    base = startCnt;
    issue(6, 16'h2101, 32'h0000_3000, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    chk(threadBusy[6] == 1'b1, "R9 busy while stalled", 32'(threadBusy), 32'h40);
    held = opRow;
    repeat (3) @(negedge clk);
    chk(opValid && opRow == held, "R11 hold under stall", opRow, held);
    issue(6, 16'h2200, 32'h0000_9999, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    issue(4, 16'h2200, 32'h0000_4000, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    issue(1, 16'h2200, 32'h0000_1111, 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
    readyMode = 1;
    waitIdle();
    chk(startLog[base % 512] == 6 && startLog[(base + 1) % 512] == 1 &&
        startLog[(base + 2) % 512] == 4, "R12 start order",
        32'({startLog[base % 512][3:0], startLog[(base + 1) % 512][3:0], startLog[(base + 2) % 512][3:0]}),
        32'h614);
    chk(threadBusy == 8'd0, "R9 busy cleared", 32'(threadBusy), 32'd0);

    // R10: write-one-to-clear, partial
    rd(12'h138, d);
    chk(d[7:0] == expIntr, "R10 status set", d, 32'(expIntr));
    wr(12'h138, 32'h0000_0001);
    expIntr[0] = 1'b0;
    rd(12'h138, d);
    chk(d[7:0] == expIntr, "R10 partial clear", d, 32'(expIntr));
    wr(12'h138, 32'h0000_00FF);
    expIntr = '0;
    rd(12'h138, d);
    chk(d[7:0] == 8'd0 && irq == 1'b0, "R10 full clear", {d[30:0], irq}, 32'd0);

    // random phase with back-pressure
    readyMode = 2;
    for (int n = 0; n < 80; n++) begin
      int t;
      int sel;
      logic [7:0] pp;
      t = $urandom_range(0, 7);
      sel = $urandom_range(0, 9);
      pp = 8'($urandom_range(0, 15));
      if (sel < 8) begin
        issue(t, opcodeFor(sel, pp), $urandom(), $urandom(), 8'h00,
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2'b01, 4'd0);
      end else begin
        case ($urandom_range(0, 3))
          0: issue(t, opcodeFor(0, pp), $urandom(), 32'h0, 8'h00, 0, 0, 2'b00, 4'd0);
          1: issue(t, 16'h2400, $urandom(), 32'h0, 8'h00, 0, 0, 2'b01, 4'd0);
          2: issue(t, opcodeFor(3, pp), $urandom(), 32'h0, 8'h02, 0, 0, 2'b01, 4'd0);
          default: issue(t, opcodeFor(1, pp), $urandom(), 32'h0, 8'h00, 1, 0, 2'b01, 4'd5);
        endcase
      end
      repeat ($urandom_range(0, 6)) @(negedge clk);
    end
    readyMode = 1;
    waitIdle();
    idle();
    rd(12'h138, d);
    chk(d[7:0] == expIntr, "R10 status after random", d, 32'(expIntr));
    chk(irq == (|expIntr), "R10 irq after random", 32'(irq), 32'(|expIntr));
    chk(threadBusy == 8'd0 && opValid == 1'b0, "R9 all idle", {23'd0, opValid, threadBusy}, 32'd0);
    finishRun();
  end

endmodule